// File: doc/BRIEF.md
# Halfword Instruction Decode Dispatcher

The block holds one fetched 32-bit word that packs two 16-bit instructions, the later one in bits 31:16. A half-select bit picks the current half. This bit is bit 1 of the location counter, which advances when a fetch starts. The opcode field of the chosen half, combined with a 2-bit bank field from a mode register, addresses a writable decode table of 16-bit entries. A dispatch request returns the selected entry as the next micro-program address.

The table is loaded through a slow write path. A write request latches the address, taken from the chosen half, and the 16-bit data. The entry is committed one clock later. A dispatch issued while that commit is still pending sees the new data through a bypass. The selected instruction half and the addressed table entry can both be read back, zero-extended to the bus width.

Top module: `halfword_dispatch`

## Requirements
- R1: After reset, `ir_rd_data` reads 0, `disp_valid` is 0 and `disp_addr` is 0. The table contents are undefined until written.
- R2: When `ir_load` is 1 at a rising edge, the instruction register captures `ir_wdata`. Otherwise it keeps its value, whatever `ir_wdata` carries.
- R3: When `lc_half` is 1, the current half is bits 15:0. When `lc_half` is 0, the current half is bits 31:16. `ir_rd_data` returns the current half of the held word in bits 15:0, with bits 31:16 zero.
- R4: The table address is {`bank_sel`, bits 15:6 of the current half}, 12 bits wide. Bits 5:0 of the half have no effect on the address. Address 4095 is reachable.
- R5: A write request latches the table address and `ram_wdata` at its edge and commits the entry at the next edge. `ram_rd_data` therefore shows the new value from the second edge on, zero-extended to 32 bits.
- R6: A dispatch request at an edge sets `disp_valid` to 1 for the following cycle, with `disp_addr` equal to the addressed entry. With no request, `disp_valid` is 0 and `disp_addr` keeps its last value.
- R7: If `ir_load` and `disp_req` are both 1 at the same edge, the lookup uses the newly loaded word.
- R8: A dispatch in the cycle right after a write request to the same address returns the newly written data.
- R9: Different `bank_sel` values with the same opcode address distinct entries.
- R10: If `ir_load` and `ram_wr_req` are both 1 at the same edge, the write address comes from the newly loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_load | input | 1 | Load strobe for the instruction register |
| ir_wdata | input | 32 | Fetched word holding two halves |
| lc_half | input | 1 | Location-counter half-select bit (1 = low half) |
| bank_sel | input | 2 | Mode-register field giving the upper table address bits |
| ram_wr_req | input | 1 | Slow write request for the decode table |
| ram_wdata | input | 16 | Data for the table write |
| ir_rd_data | output | 32 | Current half of the held word, zero-extended |
| ram_rd_data | output | 32 | Table entry at the held word's address, zero-extended |
| disp_req | input | 1 | Dispatch request |
| disp_valid | output | 1 | Dispatch result valid |
| disp_addr | output | 16 | Next micro-program address from the table |

## Verification
The embedded assertions check four things on every cycle: the register holds or captures, a write request is latched, the pending write is committed one edge later, and the dispatch output follows the request one cycle behind. Some behaviours appear only in the bench's scenarios, against its behavioural model: the half selection, the address formed from the opcode field and the bank, the two same-cycle forwarding cases, the bypass of a pending write, and the readback timing around a commit.

// File: rtl/hwd_pkg.sv
package hwd_pkg;
  localparam int unsigned HWD_HALF_W  = 16;
  localparam int unsigned HWD_HALVES  = 2;
  localparam int unsigned HWD_OPC_LSB = 6;
  localparam int unsigned HWD_BANK_W  = 2;
  localparam int unsigned HWD_ENTRY_W = 16;
  localparam int unsigned HWD_BUS_W   = 32;

  typedef enum logic {
    HALF_HIGH = 1'b0,
    HALF_LOW  = 1'b1
  } half_sel_e;
endpackage

// File: rtl/hwd_ir_stage.sv
module hwd_ir_stage
  import hwd_pkg::*;
#(
  parameter int unsigned HALF_W  = HWD_HALF_W,
  parameter int unsigned OPC_LSB = HWD_OPC_LSB,
  parameter int unsigned BANK_W  = HWD_BANK_W,
  parameter int unsigned BUS_W   = HWD_BUS_W,
  localparam int unsigned WORD_W = HALF_W * HWD_HALVES,
  localparam int unsigned OPC_W  = HALF_W - OPC_LSB,
  localparam int unsigned ADDR_W = BANK_W + OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_load,
  input  logic [WORD_W-1:0] ir_wdata,
  input  logic              lc_half,
  input  logic [BANK_W-1:0] bank_sel,
  output logic [ADDR_W-1:0] look_addr,
  output logic [ADDR_W-1:0] held_addr,
  output logic [BUS_W-1:0]  ir_rd
);
  logic [WORD_W-1:0] ir_q, ir_d;
  logic [HALF_W-1:0] held_half [HWD_HALVES];
  logic [OPC_W-1:0]  fwd_opc   [HWD_HALVES];
  logic [HALF_W-1:0] held_cur;
  logic [OPC_W-1:0]  fwd_cur;
  half_sel_e         sel;

  // next state with explicit load enable
  always_comb begin
    ir_d = ir_q;
    if (ir_load) ir_d = ir_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir_q <= '0;
    else        ir_q <= ir_d;
  end

  // per-half slices: held word for readback, forwarded word for lookup
  for (genvar h = 0; h < HWD_HALVES; h++) begin : g_half
    assign held_half[h] = ir_q[h*HALF_W +: HALF_W];
    assign fwd_opc[h]   = ir_d[h*HALF_W + OPC_LSB +: OPC_W];
  end

  assign sel      = half_sel_e'(lc_half);
  assign held_cur = (sel == HALF_LOW) ? held_half[0] : held_half[1];
  assign fwd_cur  = (sel == HALF_LOW) ? fwd_opc[0]   : fwd_opc[1];

  assign look_addr = {bank_sel, fwd_cur};
  assign held_addr = {bank_sel, held_cur[HALF_W-1:OPC_LSB]};
  assign ir_rd     = {{(BUS_W-HALF_W){1'b0}}, held_cur};

  p_ir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_load |=> $stable(ir_q));
  p_ir_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> (ir_q == $past(ir_wdata)));
endmodule

// File: rtl/hwd_decode_ram.sv
module hwd_decode_ram
  import hwd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned ENTRY_W = HWD_ENTRY_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_req,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [ENTRY_W-1:0] rd_data,
  input  logic [ADDR_W-1:0]  lk_addr,
  output logic [ENTRY_W-1:0] lk_data
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic               wp_valid_q, wp_valid_d;
  logic [ADDR_W-1:0]  wp_addr_q,  wp_addr_d;
  logic [ENTRY_W-1:0] wp_data_q,  wp_data_d;
  logic               bypass_hit;

  // slow-destination stage: latch now, commit one edge later
  always_comb begin
    wp_valid_d = wr_req;
    wp_addr_d  = wp_addr_q;
    wp_data_d  = wp_data_q;
    if (wr_req) begin
      wp_addr_d = wr_addr;
      wp_data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_valid_q <= 1'b0;
      wp_addr_q  <= '0;
      wp_data_q  <= '0;
    end else begin
      wp_valid_q <= wp_valid_d;
      wp_addr_q  <= wp_addr_d;
      wp_data_q  <= wp_data_d;
    end
  end

  // storage array, no reset
  always_ff @(posedge clk) begin
    if (wp_valid_q) mem[wp_addr_q] <= wp_data_q;
  end

  assign rd_data    = mem[rd_addr];
  assign bypass_hit = wp_valid_q && (wp_addr_q == lk_addr);
  assign lk_data    = bypass_hit ? wp_data_q : mem[lk_addr];

  p_wr_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> (wp_valid_q && wp_addr_q == $past(wr_addr) && wp_data_q == $past(wr_data)));
  p_wr_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wp_valid_q |=> (mem[$past(wp_addr_q)] == $past(wp_data_q)));
endmodule

// File: rtl/hwd_dispatch_reg.sv
module hwd_dispatch_reg
  import hwd_pkg::*;
#(
  parameter int unsigned ENTRY_W = HWD_ENTRY_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               disp_req,
  input  logic [ENTRY_W-1:0] lk_data,
  output logic               disp_valid,
  output logic [ENTRY_W-1:0] disp_addr
);
  logic               valid_q, valid_d;
  logic [ENTRY_W-1:0] addr_q,  addr_d;

  always_comb begin
    valid_d = disp_req;
    addr_d  = addr_q;
    if (disp_req) addr_d = lk_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
    end
  end

  assign disp_valid = valid_q;
  assign disp_addr  = addr_q;

  p_disp_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_req |=> (disp_valid && disp_addr == $past(lk_data)));
  p_disp_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_req |=> (!disp_valid && $stable(disp_addr)));
endmodule

// File: rtl/halfword_dispatch.sv
module halfword_dispatch
  import hwd_pkg::*;
#(
  parameter int unsigned HALF_W  = HWD_HALF_W,
  parameter int unsigned OPC_LSB = HWD_OPC_LSB,
  parameter int unsigned BANK_W  = HWD_BANK_W,
  parameter int unsigned ENTRY_W = HWD_ENTRY_W,
  parameter int unsigned BUS_W   = HWD_BUS_W,
  localparam int unsigned WORD_W = HALF_W * HWD_HALVES,
  localparam int unsigned ADDR_W = BANK_W + HALF_W - OPC_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ir_load,
  input  logic [WORD_W-1:0]  ir_wdata,
  input  logic               lc_half,
  input  logic [BANK_W-1:0]  bank_sel,
  input  logic               ram_wr_req,
  input  logic [ENTRY_W-1:0] ram_wdata,
  output logic [BUS_W-1:0]   ir_rd_data,
  output logic [BUS_W-1:0]   ram_rd_data,
  input  logic               disp_req,
  output logic               disp_valid,
  output logic [ENTRY_W-1:0] disp_addr
);
  logic [ADDR_W-1:0]  look_addr, held_addr;
  logic [ENTRY_W-1:0] rd_entry, lk_entry;

  hwd_ir_stage #(
    .HALF_W(HALF_W), .OPC_LSB(OPC_LSB), .BANK_W(BANK_W), .BUS_W(BUS_W)
  ) u_ir (
    .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .ir_wdata(ir_wdata),
    .lc_half(lc_half), .bank_sel(bank_sel),
    .look_addr(look_addr), .held_addr(held_addr), .ir_rd(ir_rd_data)
  );

  hwd_decode_ram #(
    .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)
  ) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_req(ram_wr_req), .wr_addr(look_addr),
    .wr_data(ram_wdata), .rd_addr(held_addr), .rd_data(rd_entry),
    .lk_addr(look_addr), .lk_data(lk_entry)
  );

  hwd_dispatch_reg #(
    .ENTRY_W(ENTRY_W)
  ) u_disp (
    .clk(clk), .rst_n(rst_n), .disp_req(disp_req), .lk_data(lk_entry),
    .disp_valid(disp_valid), .disp_addr(disp_addr)
  );

  assign ram_rd_data = {{(BUS_W-ENTRY_W){1'b0}}, rd_entry};
endmodule

// File: tb/halfword_dispatch_test.sv
`timescale 1ns/1ps
module halfword_dispatch_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ir_load, lc_half, ram_wr_req, disp_req;
  logic [31:0] ir_wdata;
  logic [1:0]  bank_sel;
  logic [15:0] ram_wdata;
  logic [31:0] ir_rd_data, ram_rd_data;
  logic        disp_valid;
  logic [15:0] disp_addr;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  halfword_dispatch uut (
    .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .ir_wdata(ir_wdata),
    .lc_half(lc_half), .bank_sel(bank_sel), .ram_wr_req(ram_wr_req),
    .ram_wdata(ram_wdata), .ir_rd_data(ir_rd_data), .ram_rd_data(ram_rd_data),
    .disp_req(disp_req), .disp_valid(disp_valid), .disp_addr(disp_addr)
  );

  // behavioural reference model
  logic [31:0] m_ir;
  bit          m_dv;
  logic [15:0] m_da;
  bit          m_da_ok;
  logic [15:0] m_mem [int];
  bit          m_wpv;
  int          m_wpa;
  logic [15:0] m_wpd;

  function automatic int addr_of(logic [31:0] w, logic sel_low, logic [1:0] bk);
    logic [15:0] h;
    h = sel_low ? w[15:0] : w[31:16];
    return int'(bk) * 1024 + int'(h >> 6);
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic [31:0] eff;
    int a;
    if (!rst_n) begin
      m_ir = '0; m_dv = 0; m_da = '0; m_da_ok = 1; m_wpv = 0;
    end else begin
      eff = ir_load ? ir_wdata : m_ir;
      a = addr_of(eff, lc_half, bank_sel);
      m_dv = disp_req;
      if (disp_req) begin
        if (m_wpv && m_wpa == a) begin m_da = m_wpd; m_da_ok = 1; end
        else if (m_mem.exists(a)) begin m_da = m_mem[a]; m_da_ok = 1; end
        else m_da_ok = 0;
      end
      if (m_wpv) m_mem[m_wpa] = m_wpd;
      m_wpv = ram_wr_req;
      if (ram_wr_req) begin m_wpa = a; m_wpd = ram_wdata; end
      m_ir = eff;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmp_all();
    int a;
    chk("R3 model ir readback", ir_rd_data, {16'h0, lc_half ? m_ir[15:0] : m_ir[31:16]});
    chk("R6 model dispatch valid", {31'h0, disp_valid}, {31'h0, m_dv});
    if (m_da_ok) chk("R6 model dispatch address", {16'h0, disp_addr}, {16'h0, m_da});
    a = addr_of(m_ir, lc_half, bank_sel);
    if (m_mem.exists(a)) chk("R5 model table readback", ram_rd_data, {16'h0, m_mem[a]});
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    cmp_all();
  endtask

  task automatic fill(logic [1:0] bk, logic [9:0] opc, logic [15:0] d);
    ir_load = 1; ir_wdata = {opc, 6'h0, opc, 6'h0}; bank_sel = bk;
    ram_wr_req = 1; ram_wdata = d;
    step();
    ir_load = 0; ram_wr_req = 0;
    step();
  endtask

  task automatic dispatch_once();
    disp_req = 1;
    step();
    disp_req = 0;
  endtask

  initial begin : watchdog
    #500us;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    rst_n = 0; ir_load = 0; ir_wdata = '0; lc_half = 1; bank_sel = 0;
    ram_wr_req = 0; ram_wdata = '0; disp_req = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset ir readback", ir_rd_data, 32'h0);
    chk("R1 reset disp_valid", {31'h0, disp_valid}, 32'h0);
    chk("R1 reset disp_addr", {16'h0, disp_addr}, 32'h0);
    rst_n = 1;
    step();

    // R2 / R3: load and half selection
    ir_load = 1; ir_wdata = 32'h1234_ABCD; lc_half = 1;
    step();
    ir_load = 0; ir_wdata = 32'hFFFF_FFFF;
    chk("R3 low half readback", ir_rd_data, 32'h0000_ABCD);
    lc_half = 0; #1;
    chk("R3 high half readback", ir_rd_data, 32'h0000_1234);
    step();
    chk("R2 hold without load", ir_rd_data, 32'h0000_1234);

    // populate the table
    for (int i = 0; i < 10; i++) fill(2'd0, 10'(i), 16'h0100 + 16'(i * 8));
    fill(2'd2, 10'd5,    16'hB005);
    fill(2'd3, 10'd1023, 16'hCAFE);
    fill(2'd0, 10'd1023, 16'h0FF0);

    // R4: opcode field only, low bits ignored
    bank_sel = 0; lc_half = 1;
    ir_load = 1; ir_wdata = 32'h017F_026A;
    step();
    ir_load = 0;
    dispatch_once();
    chk("R4 low half opcode 9", {16'h0, disp_addr}, 32'h0000_0148);
    lc_half = 0;
    dispatch_once();
    chk("R4 high half opcode 5", {16'h0, disp_addr}, 32'h0000_0128);
    step();
    chk("R6 no request valid low", {31'h0, disp_valid}, 32'h0);
    chk("R6 no request addr held", {16'h0, disp_addr}, 32'h0000_0128);

    // R9: bank field
    bank_sel = 2;
    dispatch_once();
    chk("R9 bank 2 opcode 5", {16'h0, disp_addr}, 32'h0000_B005);
    chk("R9 bank 2 readback", ram_rd_data, 32'h0000_B005);

    // R4 boundary: top entry
    bank_sel = 3; ir_load = 1; ir_wdata = 32'hFFC0_FFC0;
    step();
    ir_load = 0;
    dispatch_once();
    chk("R4 entry 4095", {16'h0, disp_addr}, 32'h0000_CAFE);
    bank_sel = 0;
    dispatch_once();
    chk("R9 bank 0 opcode 1023", {16'h0, disp_addr}, 32'h0000_0FF0);

    // R7: load and dispatch together
    lc_half = 1; ir_load = 1; ir_wdata = 32'h0000_00C0; disp_req = 1;
    step();
    ir_load = 0; disp_req = 0;
    chk("R7 same-cycle load dispatch", {16'h0, disp_addr}, 32'h0000_0118);

    // R5 / R8: slow write timing and bypass
    ram_wr_req = 1; ram_wdata = 16'h5A5A;
    step();
    ram_wr_req = 0;
    chk("R5 readback before commit", ram_rd_data, 32'h0000_0118);
    disp_req = 1;
    step();
    disp_req = 0;
    chk("R8 dispatch bypass", {16'h0, disp_addr}, 32'h0000_5A5A);
    chk("R5 readback after commit", ram_rd_data, 32'h0000_5A5A);

    // R10: write address from newly loaded word
    ir_load = 1; ir_wdata = 32'h0000_0080; ram_wr_req = 1; ram_wdata = 16'h7E7E;
    step();
    ir_load = 0; ram_wr_req = 0;
    step();
    chk("R10 new word entry written", ram_rd_data, 32'h0000_7E7E);
    ir_load = 1; ir_wdata = 32'h0000_00C0;
    step();
    ir_load = 0;
    chk("R10 old word entry untouched", ram_rd_data, 32'h0000_5A5A);

    repeat (3) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule